// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit settles conditional branches for a small 32-bit processor. A compare operation does not produce flags. It stores its two raw register operands in a pair of compare registers. Because the raw values are kept, any later branch can apply either a signed or an unsigned relation to the same pair.

When a branch is presented, the unit takes the condition code from the branch opcode and tests the stored pair as first operand against second operand. It then forms the sequential address and the branch target from the branch's own PC and an embedded 10-bit displacement, and registers the chosen next PC. It also registers a taken flag and an illegal-condition flag. The illegal flag tells the exception logic that the condition code is not defined. In that case the next PC stays on the branch instruction.

Top module: `branch_resolver`

## Requirements
- R1: After reset, `res_valid`, `next_pc`, `taken` and `illegal` are all zero, and both compare registers hold zero. An equal-test branch issued before any compare is therefore taken.
- R2: When `cmp_we` is high at a clock edge, `cmp_a` and `cmp_b` are stored unmodified. They are held until the next compare, and branches never change them.
- R3: Condition code 0 (opcode bits [13:10]) is taken when first equals second. Code 1 is taken when they differ.
- R4: The signed codes are taken when the relation holds on two's-complement values: 2 for first less than second, 3 for greater, 6 for greater or equal, 7 for less or equal.
- R5: The unsigned codes are taken when the relation holds on unsigned values: 4 for less, 5 for greater, 8 for greater or equal, 9 for less or equal.
- R6: A taken branch yields `next_pc` = PC + 2 + D. D is opcode bits [9:0], sign-extended and multiplied by two, so it is always even and lies between -1024 and +1022.
- R7: A branch whose legal condition is false yields `next_pc` = PC + 2 with `taken` low.
- R8: Condition codes 10 to 15 set `illegal`, clear `taken`, and yield `next_pc` equal to the branch's own PC.
- R9: `res_valid` is high in exactly the cycle after a cycle with `br_valid` high. `next_pc`, `taken` and `illegal` change only after a branch and otherwise hold their values.
- R10: A branch and a compare presented in the same cycle test the values stored before that compare. The new values apply from the next branch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_we | input | 1 | Compare strobe: store the operand pair |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | A branch is presented this cycle |
| br_opcode | input | 16 | Branch opcode: condition in [13:10], displacement in [9:0] |
| br_pc | input | 32 | Address of the branch instruction |
| res_valid | output | 1 | Result registers hold a new branch result |
| next_pc | output | 32 | Resolved next program counter |
| taken | output | 1 | Branch condition held |
| illegal | output | 1 | Condition code was undefined |

## Verification
Each branch result is due one clock edge after the strobe that presented it. The compare registers take effect at the same edge that samples a compare, so a branch presented one cycle later already sees the new pair. The driver applies inputs on the falling edge and pushes the expected result for every branch into a queue. The monitor checks on the following falling edge, where `res_valid` must be high and the front of the queue is compared. Idle cycles are checked for a low `res_valid` and unchanged result registers, and same-cycle compare-and-branch pairs are checked against the previously stored operands.

// File: rtl/brr_pkg.sv
package brr_pkg;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned NUM_CONDS = 10;

  // Condition selector values; the numbering is fixed by the opcode encoding.
  typedef enum logic [SEL_W-1:0] {
    SEL_EQ  = 4'd0,
    SEL_NE  = 4'd1,
    SEL_LT  = 4'd2,
    SEL_GT  = 4'd3,
    SEL_LTU = 4'd4,
    SEL_GTU = 4'd5,
    SEL_GE  = 4'd6,
    SEL_LE  = 4'd7,
    SEL_GEU = 4'd8,
    SEL_LEU = 4'd9
  } cond_sel_e;

  // Basic relations between the stored pair, from which every test is built.
  typedef struct packed {
    logic same;
    logic below_s;
    logic below_u;
  } rel_t;
endpackage

// File: rtl/brr_cmp_latch.sv
module brr_cmp_latch #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [XLEN-1:0] a_in,
  input  logic [XLEN-1:0] b_in,
  output logic [XLEN-1:0] a_q,
  output logic [XLEN-1:0] b_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (we) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end
endmodule

// File: rtl/brr_cond_eval.sv
module brr_cond_eval
  import brr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  lhs,
  input  logic [XLEN-1:0]  rhs,
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic             bad
);
  rel_t rel;

  always_comb begin
    rel.same    = (lhs == rhs);
    rel.below_s = ($signed(lhs) < $signed(rhs));
    rel.below_u = (lhs < rhs);
  end

  always_comb begin
    hit = 1'b0;
    bad = 1'b0;
    case (sel)
      SEL_EQ:  hit = rel.same;
      SEL_NE:  hit = !rel.same;
      SEL_LT:  hit = rel.below_s;
      SEL_GT:  hit = !rel.below_s && !rel.same;
      SEL_LTU: hit = rel.below_u;
      SEL_GTU: hit = !rel.below_u && !rel.same;
      SEL_GE:  hit = !rel.below_s;
      SEL_LE:  hit = rel.below_s || rel.same;
      SEL_GEU: hit = !rel.below_u;
      SEL_LEU: hit = rel.below_u || rel.same;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/brr_target.sv
module brr_target #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned DISP_W     = 10,
  parameter int unsigned INSN_BYTES = 2
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   jump_pc
);
  localparam int unsigned EXT_W = XLEN - DISP_W - 1;

  logic [XLEN-1:0] offset;

  always_comb begin
    offset  = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
    seq_pc  = pc + XLEN'(INSN_BYTES);
    jump_pc = seq_pc + offset;
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brr_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned OP_W   = 16,
  parameter int unsigned DISP_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp_we,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  input  logic            br_valid,
  input  logic [OP_W-1:0] br_opcode,
  input  logic [XLEN-1:0] br_pc,
  output logic            res_valid,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic            illegal
);
  localparam int unsigned SEL_LO = DISP_W;
  localparam int unsigned SEL_HI = DISP_W + SEL_W - 1;

  logic [XLEN-1:0]  stored_a, stored_b;
  logic [SEL_W-1:0] sel;
  logic             cond_hit, cond_bad;
  logic [XLEN-1:0]  seq_pc, jump_pc;
  logic [XLEN-1:0]  pick_pc;
  logic             unused_opcode_hi;

  assign sel              = br_opcode[SEL_HI:SEL_LO];
  assign unused_opcode_hi = ^br_opcode[OP_W-1:SEL_HI+1];

  brr_cmp_latch #(.XLEN(XLEN)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .we   (cmp_we),
    .a_in (cmp_a),
    .b_in (cmp_b),
    .a_q  (stored_a),
    .b_q  (stored_b)
  );

  brr_cond_eval #(.XLEN(XLEN)) u_eval (
    .lhs (stored_a),
    .rhs (stored_b),
    .sel (sel),
    .hit (cond_hit),
    .bad (cond_bad)
  );

  brr_target #(.XLEN(XLEN), .DISP_W(DISP_W), .INSN_BYTES(2)) u_tgt (
    .pc      (br_pc),
    .disp    (br_opcode[DISP_W-1:0]),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  always_comb begin
    if (cond_bad)      pick_pc = br_pc;
    else if (cond_hit) pick_pc = jump_pc;
    else               pick_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= br_valid;
      if (br_valid) begin
        next_pc <= pick_pc;
        taken   <= cond_hit && !cond_bad;
        illegal <= cond_bad;
      end
    end
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned OP_W   = 16,
  parameter int unsigned DISP_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            br_valid,
  input logic [OP_W-1:0] br_opcode,
  input logic [XLEN-1:0] br_pc,
  input logic            res_valid,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic            illegal
);
  logic [3:0]      code_in;
  logic [XLEN-1:0] disp_bytes;

  assign code_in    = br_opcode[DISP_W+3:DISP_W];
  assign disp_bytes = XLEN'($signed(br_opcode[DISP_W-1:0])) <<< 1;

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> res_valid); // R9

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> !res_valid); // R9

  AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> $stable(next_pc) && $stable(taken) && $stable(illegal)); // R9

  AST_ILLEGAL_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !taken); // R8

  AST_ILLEGAL_STAYS: assert property (@(posedge clk) disable iff (rst)
    (br_valid && code_in >= 4'd10) |=> illegal && (next_pc == $past(br_pc))); // R8

  AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (rst)
    (br_valid && code_in < 4'd10) |=> !illegal &&
      (taken || next_pc == $past(br_pc) + XLEN'(2))); // R7

  AST_TARGET_PC: assert property (@(posedge clk) disable iff (rst)
    (br_valid && code_in < 4'd10) |=>
      (!taken || next_pc == $past(br_pc) + XLEN'(2) + $past(disp_bytes))); // R6
endmodule

bind branch_resolver branch_resolver_chk #(
  .XLEN(XLEN), .OP_W(OP_W), .DISP_W(DISP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .br_valid  (br_valid),
  .br_opcode (br_opcode),
  .br_pc     (br_pc),
  .res_valid (res_valid),
  .next_pc   (next_pc),
  .taken     (taken),
  .illegal   (illegal)
);

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_we = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0;
  logic        br_valid = 1'b0;
  logic [15:0] br_opcode = '0;
  logic [31:0] br_pc = '0;
  logic        res_valid;
  logic [31:0] next_pc;
  logic        taken, illegal;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] pc;
    logic        tk;
    logic        il;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic [31:0] mdl_a = '0, mdl_b = '0;
  logic [31:0] last_pc = '0;

  always #2 clk = ~clk;

  branch_resolver u_branch_resolver (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_valid(br_valid), .br_opcode(br_opcode), .br_pc(br_pc),
    .res_valid(res_valid), .next_pc(next_pc), .taken(taken), .illegal(illegal)
  );

  function automatic logic ref_hit(int c, logic [31:0] a, logic [31:0] b);
    int signed sa = a;
    int signed sb = b;
    case (c)
      0: return a == b;
      1: return a != b;
      2: return sa < sb;
      3: return sa > sb;
      4: return a < b;
      5: return a > b;
      6: return sa >= sb;
      7: return sa <= sb;
      8: return a >= b;
      9: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] mk_op(int c, int d);
    return {2'b11, 4'(c), 10'(d)};
  endfunction

  task automatic note(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expected result pushed for every branch.
  task automatic drive(input logic cw, input logic [31:0] a, input logic [31:0] b,
                       input logic bv, input int c, input int d,
                       input logic [31:0] pc, input string tag);
    exp_t e;
    int signed off;
    @(negedge clk);
    cmp_we = cw; cmp_a = a; cmp_b = b;
    br_valid = bv; br_opcode = mk_op(c, d); br_pc = pc;
    if (bv) begin
      off = (d >= 512) ? (d - 1024) * 2 : d * 2;
      e.tag = tag;
      if (c >= 10) begin
        e.pc = pc; e.tk = 1'b0; e.il = 1'b1;
      end else begin
        e.il = 1'b0;
        e.tk = ref_hit(c, mdl_a, mdl_b);
        e.pc = e.tk ? pc + 32'd2 + 32'(off) : pc + 32'd2;
      end
      last_pc = e.pc;
      sbq.push_back(e);
    end
    if (cw) begin
      mdl_a = a; mdl_b = b;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cmp_we = 1'b0; br_valid = 1'b0;
  endtask

  task automatic cmp_only(input logic [31:0] a, input logic [31:0] b);
    drive(1'b1, a, b, 1'b0, 0, 0, 32'h0, "R2");
  endtask

  task automatic br(input int c, input int d, input logic [31:0] pc, input string tag);
    drive(1'b0, 32'h0, 32'h0, 1'b1, c, d, pc, tag);
  endtask

  // Monitor: every result cycle pops one expected item.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && res_valid) begin
      if (sbq.size() == 0) begin
        note("R9", "unexpected res_valid", 32'd1, 32'd0);
      end else begin
        e = sbq.pop_front();
        note(e.tag, "next_pc", next_pc, e.pc);
        note(e.tag, "taken", 32'(taken), 32'(e.tk));
        note(e.tag, "illegal", 32'(illegal), 32'(e.il));
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pa [4];
    logic [31:0] pb [4];
    pa[0] = 32'd5;        pb[0] = 32'd5;
    pa[1] = 32'hFFFFFFFD; pb[1] = 32'd2;
    pa[2] = 32'd7;        pb[2] = 32'h80000000;
    pa[3] = 32'd1;        pb[3] = 32'd9;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values at the ports
    note("R1", "res_valid", 32'(res_valid), 32'd0);
    note("R1", "next_pc", next_pc, 32'd0);
    note("R1", "taken", 32'(taken), 32'd0);
    note("R1", "illegal", 32'(illegal), 32'd0);
    // R1: zeroed compare registers make eq taken
    br(0, 4, 32'h100, "R1");
    idle();

    // R3 R4 R5 across operand patterns; R2 holds the pair through branches
    for (int p = 0; p < 4; p++) begin
      cmp_only(pa[p], pb[p]);
      for (int c = 0; c < 10; c++) begin
        br(c, 8 + c, 32'h1000 + 32'(p * 64), (c < 2) ? "R3" : ((c == 4 || c == 5 || c >= 8) ? "R5" : "R4"));
      end
      idle();
    end
    // R2: pair still held after many branches; also equal pair on signed ge/le
    cmp_only(32'h12345678, 32'h12345678);
    idle(); idle();
    br(6, 3, 32'h2000, "R2");
    br(7, 3, 32'h2000, "R2");
    br(8, 3, 32'h2000, "R2");

    // R6: displacement extremes
    br(0, 10'h3FF, 32'h4000, "R6");
    br(0, 10'h200, 32'h4000, "R6");
    br(0, 10'h1FF, 32'h4000, "R6");
    br(0, 0,       32'h4000, "R6");
    // R7: not taken
    br(1, 10'h155, 32'h5000, "R7");
    idle();

    // R8: each undefined code
    for (int c = 10; c < 16; c++) br(c, 20, 32'h6000 + 32'(c), "R8");
    idle();

    // R9: idle cycles keep results
    idle(); idle();
    note("R9", "idle res_valid", 32'(res_valid), 32'd0);
    note("R9", "held next_pc", next_pc, last_pc);
    note("R9", "held illegal", 32'(illegal), 32'd1);

    // R10: compare and branch together use the old pair
    cmp_only(32'd3, 32'd3);
    drive(1'b1, 32'd1, 32'd2, 1'b1, 0, 6, 32'h7000, "R10");
    br(0, 6, 32'h7000, "R10");
    br(4, 6, 32'h7000, "R10");
    idle(); idle(); idle();

    note("R9", "scoreboard drained", 32'(sbq.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule